// File: doc/BRIEF.md
# Soft-Switch Memory Bank Controller

This block sits beside an 8-bit processor with a 64 KB address space. It decodes every access and keeps the mode flip-flops that decide where that access lands: main RAM, auxiliary RAM, ROM, or nowhere. A write into the mode-switch page flips a single flag. The address alone carries the meaning, so the data bus is not looked at. Each switch owns an address pair, and address bit 0 gives the new value. The flag that enables the internal slot ROM breaks this rule and uses the inverted sense. A read of the status page returns a single flag in bit 7. The video state that the status page reports comes in from outside on dedicated inputs.

The upper 12 KB holds a banked language-card area. Any read or write in the language-card page loads a 4-bit state with `addr & 0x0B`. The state register is an enumerated machine with eight states:

| State | Bank | Read from | Writes |
|---|---|---|---|
| `LC_B2_RAM_RO` | bank 2 | RAM | blocked |
| `LC_B2_ROM_WR` | bank 2 | ROM | to RAM |
| `LC_B2_ROM_RO` | bank 2 | ROM | blocked |
| `LC_B2_RAM_RW` | bank 2 | RAM | to RAM |
| `LC_B1_RAM_RO` | bank 1 | RAM | blocked |
| `LC_B1_ROM_WR` | bank 1 | ROM | to RAM |
| `LC_B1_ROM_RO` | bank 1 | ROM | blocked |
| `LC_B1_RAM_RW` | bank 1 | RAM | to RAM |

From any state, an access to `$C080+n` moves the machine to the state whose code is `n & 0x0B`. Every other access leaves the state where it is. Reset returns the machine to `LC_B2_RAM_RO`.

The outputs `tgt_sel` and `phys_off` are combinational from the address, the strobes and the current flip-flops. The memory arrays use them in the same cycle. State changes take effect at the clock edge that ends the access.

Top module: `bank_switch_ctrl`

## Requirements
- R1: A write to `$C000-$C00F` updates flag number `addr[3:1]`. The flag order is: 0 dual-page store, 1 aux read, 2 aux write, 3 internal slot ROM, 4 alternate zero page, 5 slot-3 ROM, 6 wide column, 7 alternate charset. Odd addresses set the flag and even addresses clear it. Reads of these addresses leave every flag unchanged.
- R2: The internal slot ROM flag (index 3) uses the inverted sense: a write to `$C006` sets it and a write to `$C007` clears it.
- R3: A read of `$C013-$C01F` drives `stat_valid`=1 and returns a flag in bit 7, with bits 6:0 at zero. The flags in address order are: aux read, aux write, internal slot ROM, alternate zero page, slot-3 ROM, dual-page store, `vid_vblank`, `vid_text`, `vid_mixed`, `vid_page2`, `vid_hires`, alternate charset, wide column. Writes drive `stat_valid`=0, and so do reads of `$C010` and of any address outside `$C011-$C01F`.
- R4: A read or a write of `$C080-$C08F` loads the language-card state with `addr & 0x0B`. An access anywhere else keeps the state.
- R5: In the `$D000-$DFFF` window, state bit 3 clear selects bank 2 with `phys_off` = `addr`. State bit 3 set selects bank 1 with `phys_off` = `addr - $1000` (range `$C000-$CFFF`). A ROM read always uses `phys_off` = `addr`.
- R6: State bits 1:0 of the language-card state set the access rules:
  - 00: reads RAM, writes blocked.
  - 01: reads ROM, writes go to RAM.
  - 10: reads ROM, writes blocked.
  - 11: reads and writes RAM.
- R7: The `$E000-$FFFF` window follows the same read and write rules as R6, always with `phys_off` = `addr`.
- R8: A read of `$C011` returns `0x80` while bank 2 is selected and `0x00` otherwise. A read of `$C012` returns `0x80` when language-card reads come from RAM (state bits 1:0 equal) and `0x00` otherwise.
- R9: With the alternate zero page flag set, `$0000-$01FF` and language-card RAM accesses target aux RAM. With the flag clear they target main RAM.
- R10: For `$0200-$BFFF`, reads target aux RAM when the aux read flag is set, and writes target aux RAM when the aux write flag is set. Otherwise both target main RAM.
- R11: While the dual-page store flag is set, `vid_page2` alone chooses aux (1) or main (0) for reads and writes of `$0400-$07FF`.
- R12: A synchronous reset clears all eight flags and puts the language-card state in `LC_B2_RAM_RO`.
- R13: `$C000-$C0FF` has target none. For `$C100-$CFFF`, reads target ROM with `phys_off` = `addr` and writes have target none. Target codes: 0 main, 1 aux, 2 ROM, 3 none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| vid_vblank | input | 1 | Vertical blank state, reported on status read |
| vid_text | input | 1 | Text mode state, reported on status read |
| vid_mixed | input | 1 | Mixed mode state, reported on status read |
| vid_page2 | input | 1 | Display page select; also steers `$0400-$07FF` under dual-page store |
| vid_hires | input | 1 | Graphics mode state, reported on status read |
| tgt_sel | output | 2 | Access target: 0 main, 1 aux, 2 ROM, 3 none |
| phys_off | output | 16 | Offset inside the selected target |
| stat_valid | output | 1 | Current read hits a status location |
| stat_data | output | 8 | Status byte, flag in bit 7 |

## Verification
The properties assume that `rd` and `wr` are never high together and that each strobe marks exactly one access, so the one-cycle-later checks on flags and language-card state see a single cause. The bench drives the strobes on the falling edge. It raises at most one of them and holds it across exactly one rising edge when state is meant to change. For combinational probes, it drops the strobe again before any rising edge, which keeps a probe from disturbing the flip-flops.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        TGT_MAIN = 2'd0,
        TGT_AUX  = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef enum logic [3:0] {
        LC_B2_RAM_RO = 4'h0,
        LC_B2_ROM_WR = 4'h1,
        LC_B2_ROM_RO = 4'h2,
        LC_B2_RAM_RW = 4'h3,
        LC_B1_RAM_RO = 4'h8,
        LC_B1_ROM_WR = 4'h9,
        LC_B1_ROM_RO = 4'hA,
        LC_B1_RAM_RW = 4'hB
    } lc_state_e;

    // bit order of this struct is the switch index order (addr[3:1])
    typedef struct packed {
        logic altchar;
        logic col80;
        logic slotc3;
        logic altzp;
        logic slotcx;
        logic ramwrt;
        logic ramrd;
        logic store80;
    } flags_t;

    localparam int NUM_FLAGS = 8;
    localparam logic [3:0] LC_MASK = 4'hB;

endpackage

// File: rtl/bsc_switch_reg.sv
module bsc_switch_reg
    import bsc_pkg::*;
#(
    parameter logic [11:0] SW_PAGE = 12'hC00,
    parameter int          INV_IDX = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        wr,
    output flags_t      flags
);
    localparam int IDX_W = $clog2(NUM_FLAGS);

    logic [NUM_FLAGS-1:0] bits;
    logic                 page_hit;

    assign page_hit = wr && (addr[15:4] == SW_PAGE);

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            localparam logic INV = (i == INV_IDX);
            always_ff @(posedge clk) begin
                if (rst)
                    bits[i] <= 1'b0;
                else if (page_hit && (addr[IDX_W:1] == IDX_W'(i)))
                    bits[i] <= addr[0] ^ INV;
            end
        end
    endgenerate

    assign flags = flags_t'(bits);

    AST_SW_SET_RAMRD: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'hC003) |=> flags.ramrd);                 // R1
    AST_SW_CLR_ALTZP: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'hC008) |=> !flags.altzp);                // R1
    AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !page_hit |=> $stable(bits));                              // R1
    AST_SW_INV_SET: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'hC006) |=> flags.slotcx);                // R2
    AST_SW_INV_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 16'hC007) |=> !flags.slotcx);               // R2
    AST_SW_RESET: assert property (@(posedge clk)
        rst |=> (bits == '0));                                     // R12

endmodule

// File: rtl/bsc_lc_fsm.sv
module bsc_lc_fsm
    import bsc_pkg::*;
#(
    parameter logic [11:0] LC_PAGE = 12'hC08
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    output lc_state_e   state,
    output logic        rd_ram,
    output logic        wr_ram,
    output logic        bank1
);
    lc_state_e nxt;
    logic      hit;

    assign hit = (rd || wr) && (addr[15:4] == LC_PAGE);

    always_comb begin
        nxt = state;
        if (hit)
            nxt = lc_state_e'(addr[3:0] & LC_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= LC_B2_RAM_RO;
        else
            state <= nxt;
    end

    always_comb begin
        rd_ram = 1'b0;
        wr_ram = 1'b0;
        bank1  = 1'b0;
        unique case (state)
            LC_B2_RAM_RO: begin rd_ram = 1'b1;                                  end
            LC_B2_ROM_WR: begin                 wr_ram = 1'b1;                  end
            LC_B2_ROM_RO: begin                                                 end
            LC_B2_RAM_RW: begin rd_ram = 1'b1;  wr_ram = 1'b1;                  end
            LC_B1_RAM_RO: begin rd_ram = 1'b1;                  bank1 = 1'b1;   end
            LC_B1_ROM_WR: begin                 wr_ram = 1'b1;  bank1 = 1'b1;   end
            LC_B1_ROM_RO: begin                                 bank1 = 1'b1;   end
            LC_B1_RAM_RW: begin rd_ram = 1'b1;  wr_ram = 1'b1;  bank1 = 1'b1;   end
            default:      begin                                                 end
        endcase
    end

    AST_LC_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit |=> (state == ($past(addr[3:0]) & LC_MASK)));          // R4
    AST_LC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(state));                                  // R4
    AST_LC_RESET: assert property (@(posedge clk)
        rst |=> (state == LC_B2_RAM_RO));                          // R12

endmodule

// File: rtl/bsc_router.sv
module bsc_router
    import bsc_pkg::*;
#(
    parameter logic [15:0] ZP_END   = 16'h0200,
    parameter logic [15:0] IO_BASE  = 16'hC000,
    parameter logic [15:0] LC_BASE  = 16'hD000,
    parameter logic [5:0]  TXT_PAGE = 6'b000001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        wr,
    input  flags_t      flags,
    input  logic        page2,
    input  logic        lc_rd_ram,
    input  logic        lc_wr_ram,
    input  logic        lc_bank1,
    output tgt_e        tgt,
    output logic [15:0] off
);
    tgt_e ram_tgt;
    logic sel_aux;

    assign ram_tgt = flags.altzp ? TGT_AUX : TGT_MAIN;

    always_comb begin
        off     = addr;
        tgt     = TGT_NONE;
        sel_aux = 1'b0;
        if (addr < ZP_END) begin
            tgt = ram_tgt;
        end else if (addr < IO_BASE) begin
            sel_aux = wr ? flags.ramwrt : flags.ramrd;
            if (flags.store80 && (addr[15:10] == TXT_PAGE))
                sel_aux = page2;
            tgt = sel_aux ? TGT_AUX : TGT_MAIN;
        end else if (addr < LC_BASE) begin
            if (!wr && (addr[11:8] != 4'h0))
                tgt = TGT_ROM;
        end else begin
            if (wr)
                tgt = lc_wr_ram ? ram_tgt : TGT_NONE;
            else
                tgt = lc_rd_ram ? ram_tgt : TGT_ROM;
            if ((addr[15:12] == LC_BASE[15:12]) && lc_bank1 &&
                (tgt == TGT_MAIN || tgt == TGT_AUX))
                off = {4'hC, addr[11:0]};
        end
    end

    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr |-> (tgt != TGT_ROM));                                  // R6
    AST_BANK1_OFFSET: assert property (@(posedge clk) disable iff (rst)
        ((addr[15:12] == 4'hD) && lc_bank1 && (tgt != TGT_ROM) && (tgt != TGT_NONE))
        |-> (off[15:12] == 4'hC));                                 // R5
    AST_HIGH_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (addr[15:13] == 3'b111) |-> (off == addr));                // R7
    AST_IO_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (addr[15:8] == 8'hC0) |-> (tgt == TGT_NONE));              // R13

endmodule

// File: rtl/bsc_status.sv
module bsc_status
    import bsc_pkg::*;
#(
    parameter logic [11:0] STAT_PAGE = 12'hC01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        rd,
    input  flags_t      flags,
    input  logic        lc_bank1,
    input  logic        lc_rd_ram,
    input  logic        vblank,
    input  logic        text,
    input  logic        mixed,
    input  logic        page2,
    input  logic        hires,
    output logic        valid,
    output logic [7:0]  data
);
    logic bit7;

    assign valid = rd && (addr[15:4] == STAT_PAGE) && (addr[3:0] != 4'h0);

    always_comb begin
        case (addr[3:0])
            4'h1:    bit7 = !lc_bank1;
            4'h2:    bit7 = lc_rd_ram;
            4'h3:    bit7 = flags.ramrd;
            4'h4:    bit7 = flags.ramwrt;
            4'h5:    bit7 = flags.slotcx;
            4'h6:    bit7 = flags.altzp;
            4'h7:    bit7 = flags.slotc3;
            4'h8:    bit7 = flags.store80;
            4'h9:    bit7 = vblank;
            4'hA:    bit7 = text;
            4'hB:    bit7 = mixed;
            4'hC:    bit7 = page2;
            4'hD:    bit7 = hires;
            4'hE:    bit7 = flags.altchar;
            4'hF:    bit7 = flags.col80;
            default: bit7 = 1'b0;
        endcase
    end

    assign data = valid ? {bit7, 7'b0} : 8'h00;

    AST_STAT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        valid |-> (data[6:0] == 7'b0));                            // R3
    AST_STAT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd |-> !valid);                                           // R3

endmodule

// File: rtl/bank_switch_ctrl.sv
module bank_switch_ctrl
    import bsc_pkg::*;
#(
    parameter logic [11:0] SW_PAGE   = 12'hC00,
    parameter logic [11:0] STAT_PAGE = 12'hC01,
    parameter logic [11:0] LC_PAGE   = 12'hC08
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic        vid_vblank,
    input  logic        vid_text,
    input  logic        vid_mixed,
    input  logic        vid_page2,
    input  logic        vid_hires,
    output logic [1:0]  tgt_sel,
    output logic [15:0] phys_off,
    output logic        stat_valid,
    output logic [7:0]  stat_data
);
    flags_t    flags;
    lc_state_e lc_state;
    logic      lc_rd_ram, lc_wr_ram, lc_bank1;
    tgt_e      tgt;

    bsc_switch_reg #(.SW_PAGE(SW_PAGE), .INV_IDX(3)) u_sw (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .flags(flags)
    );

    bsc_lc_fsm #(.LC_PAGE(LC_PAGE)) u_lc (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .state(lc_state), .rd_ram(lc_rd_ram), .wr_ram(lc_wr_ram), .bank1(lc_bank1)
    );

    bsc_router u_rt (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .flags(flags),
        .page2(vid_page2), .lc_rd_ram(lc_rd_ram), .lc_wr_ram(lc_wr_ram),
        .lc_bank1(lc_bank1), .tgt(tgt), .off(phys_off)
    );

    bsc_status #(.STAT_PAGE(STAT_PAGE)) u_st (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .flags(flags),
        .lc_bank1(lc_bank1), .lc_rd_ram(lc_rd_ram),
        .vblank(vid_vblank), .text(vid_text), .mixed(vid_mixed),
        .page2(vid_page2), .hires(vid_hires),
        .valid(stat_valid), .data(stat_data)
    );

    assign tgt_sel = tgt;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));                                              // R1
    AST_LC_BIT2_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (lc_state[2] == 1'b0));                                    // R4

endmodule

// File: tb/bank_switch_ctrl_test.sv
module bank_switch_ctrl_test;
    localparam logic [1:0] MAIN = 2'd0, AUX = 2'd1, ROM = 2'd2, NONE = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        rd = 1'b0, wr = 1'b0;
    logic        vid_vblank = 1'b0, vid_text = 1'b0, vid_mixed = 1'b0;
    logic        vid_page2 = 1'b0, vid_hires = 1'b0;
    logic [1:0]  tgt_sel;
    logic [15:0] phys_off;
    logic        stat_valid;
    logic [7:0]  stat_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0]  p_tgt;
    logic [15:0] p_off;
    logic        p_sv;
    logic [7:0]  p_sd;

    bank_switch_ctrl uut (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr),
        .vid_vblank(vid_vblank), .vid_text(vid_text), .vid_mixed(vid_mixed),
        .vid_page2(vid_page2), .vid_hires(vid_hires),
        .tgt_sel(tgt_sel), .phys_off(phys_off),
        .stat_valid(stat_valid), .stat_data(stat_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // strobe held across one rising edge: state may change
    task automatic access(input logic [15:0] a, input logic w);
        @(negedge clk);
        addr = a; rd = !w; wr = w;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    // strobe raised and dropped between edges: outputs only
    task automatic probe(input logic [15:0] a, input logic w);
        @(negedge clk);
        addr = a; rd = !w; wr = w;
        #1;
        p_tgt = tgt_sel; p_off = phys_off; p_sv = stat_valid; p_sd = stat_data;
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic stat(input string req, input logic [15:0] a, input logic [7:0] exp);
        probe(a, 1'b0);
        check(req, {23'b0, p_sv, p_sd}, {23'b0, 1'b1, exp});
    endtask

    task automatic route(input string req, input logic [15:0] a, input logic w,
                         input logic [1:0] et, input logic [15:0] eo);
        probe(a, w);
        check(req, {14'b0, p_tgt, p_off}, {14'b0, et, eo});
    endtask

    task automatic t_reset;
        route("R12 zp after reset", 16'h0100, 1'b0, MAIN, 16'h0100);
        stat("R12 aux read flag", 16'hC013, 8'h00);
        stat("R12 alt zp flag", 16'hC016, 8'h00);
        stat("R12 store flag", 16'hC018, 8'h00);
        stat("R8 bank2 after reset", 16'hC011, 8'h80);
        stat("R8 ram read after reset", 16'hC012, 8'h80);
        route("R6 read ram state 0", 16'hD000, 1'b0, MAIN, 16'hD000);
        route("R6 write blocked state 0", 16'hD000, 1'b1, NONE, 16'hD000);
    endtask

    task automatic t_flags;
        access(16'hC003, 1'b1);
        route("R10 aux read", 16'h3000, 1'b0, AUX, 16'h3000);
        route("R10 write stays main", 16'h3000, 1'b1, MAIN, 16'h3000);
        stat("R1 aux read set", 16'hC013, 8'h80);
        access(16'hC005, 1'b1);
        route("R10 aux write", 16'h3000, 1'b1, AUX, 16'h3000);
        stat("R1 aux write set", 16'hC014, 8'h80);
        access(16'hC002, 1'b1);
        access(16'hC004, 1'b1);
        route("R10 back to main", 16'h3000, 1'b0, MAIN, 16'h3000);
        access(16'hC006, 1'b1);
        stat("R2 even sets slot rom", 16'hC015, 8'h80);
        access(16'hC007, 1'b1);
        stat("R2 odd clears slot rom", 16'hC015, 8'h00);
        access(16'hC003, 1'b0);
        stat("R1 read does not switch", 16'hC013, 8'h00);
        access(16'hC00B, 1'b1);
        access(16'hC00D, 1'b1);
        access(16'hC00F, 1'b1);
        stat("R3 slot3 flag", 16'hC017, 8'h80);
        stat("R3 wide col flag", 16'hC01F, 8'h80);
        stat("R3 charset flag", 16'hC01E, 8'h80);
        access(16'hC00A, 1'b1);
        access(16'hC00C, 1'b1);
        access(16'hC00E, 1'b1);
        stat("R1 charset cleared", 16'hC01E, 8'h00);
    endtask

    task automatic t_zero_page;
        access(16'hC009, 1'b1);
        route("R9 zp aux read", 16'h0050, 1'b0, AUX, 16'h0050);
        route("R9 stack aux write", 16'h01FF, 1'b1, AUX, 16'h01FF);
        route("R10 0200 not zp", 16'h0200, 1'b0, MAIN, 16'h0200);
        stat("R3 alt zp flag", 16'hC016, 8'h80);
        route("R9 lc window aux", 16'hD000, 1'b0, AUX, 16'hD000);
    endtask

    task automatic t_store80;
        access(16'hC005, 1'b1);
        access(16'hC001, 1'b1);
        vid_page2 = 1'b1;
        route("R11 page2 aux read", 16'h0500, 1'b0, AUX, 16'h0500);
        route("R11 outside text page", 16'h0300, 1'b0, MAIN, 16'h0300);
        route("R10 aux write outside", 16'h0300, 1'b1, AUX, 16'h0300);
        stat("R3 page2 status", 16'hC01C, 8'h80);
        vid_page2 = 1'b0;
        route("R11 page1 overrides aux write", 16'h0500, 1'b1, MAIN, 16'h0500);
        stat("R3 store flag", 16'hC018, 8'h80);
        access(16'hC000, 1'b1);
        vid_page2 = 1'b1;
        route("R11 store off uses aux write", 16'h07FF, 1'b1, AUX, 16'h07FF);
        vid_page2 = 1'b0;
        access(16'hC004, 1'b1);
    endtask

    task automatic t_lang_card;
        access(16'hC008, 1'b1);
        access(16'hC08B, 1'b0);
        route("R5 bank1 offset", 16'hD123, 1'b0, MAIN, 16'hC123);
        route("R7 high window write", 16'hE000, 1'b1, MAIN, 16'hE000);
        stat("R8 bank1 status", 16'hC011, 8'h00);
        stat("R8 ram read status", 16'hC012, 8'h80);
        access(16'hC081, 1'b1);
        route("R6 read rom", 16'hD010, 1'b0, ROM, 16'hD010);
        route("R6 write ram", 16'hD010, 1'b1, MAIN, 16'hD010);
        stat("R8 rom read status", 16'hC012, 8'h00);
        stat("R8 bank2 status", 16'hC011, 8'h80);
        access(16'hC08A, 1'b0);
        route("R7 high write blocked", 16'hF000, 1'b1, NONE, 16'hF000);
        route("R7 high read rom", 16'hF000, 1'b0, ROM, 16'hF000);
        route("R5 rom read keeps addr", 16'hD200, 1'b0, ROM, 16'hD200);
        route("R6 write blocked", 16'hD200, 1'b1, NONE, 16'hD200);
        access(16'h1234, 1'b0);
        access(16'hC090, 1'b1);
        route("R4 other access holds", 16'hF000, 1'b1, NONE, 16'hF000);
        access(16'hC08F, 1'b0);
        route("R5 bank1 write offset", 16'hD400, 1'b1, MAIN, 16'hC400);
        access(16'hC009, 1'b1);
        route("R9 bank1 aux", 16'hDFFF, 1'b0, AUX, 16'hCFFF);
        route("R9 high aux write", 16'hFFFF, 1'b1, AUX, 16'hFFFF);
        access(16'hC008, 1'b1);
        access(16'hC084, 1'b1);
        route("R4 mask to state 0 write", 16'hD000, 1'b1, NONE, 16'hD000);
        route("R4 mask to state 0 read", 16'hD000, 1'b0, MAIN, 16'hD000);
        stat("R8 bank2 again", 16'hC011, 8'h80);
    endtask

    task automatic t_io_page;
        route("R13 slot rom read", 16'hC100, 1'b0, ROM, 16'hC100);
        route("R13 slot rom write", 16'hC100, 1'b1, NONE, 16'hC100);
        route("R13 io page", 16'hC050, 1'b0, NONE, 16'hC050);
        route("R13 top of slot rom", 16'hCFFF, 1'b0, ROM, 16'hCFFF);
    endtask

    task automatic t_video_status;
        vid_vblank = 1'b1; vid_text = 1'b1; vid_mixed = 1'b0; vid_hires = 1'b1;
        stat("R3 vblank", 16'hC019, 8'h80);
        stat("R3 text", 16'hC01A, 8'h80);
        stat("R3 mixed", 16'hC01B, 8'h00);
        stat("R3 hires", 16'hC01D, 8'h80);
        probe(16'hC010, 1'b0);
        check("R3 C010 not status", {31'b0, p_sv}, 32'd0);
        probe(16'hC013, 1'b1);
        check("R3 write not status", {31'b0, p_sv}, 32'd0);
        vid_vblank = 1'b0; vid_text = 1'b0; vid_hires = 1'b0;
    endtask

    task automatic t_midrun_reset;
        access(16'hC003, 1'b1);
        access(16'hC009, 1'b1);
        access(16'hC08B, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        stat("R12 aux read cleared", 16'hC013, 8'h00);
        stat("R12 alt zp cleared", 16'hC016, 8'h00);
        stat("R12 bank2 restored", 16'hC011, 8'h80);
        stat("R12 ram read restored", 16'hC012, 8'h80);
        route("R12 main read", 16'h3000, 1'b0, MAIN, 16'h3000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_flags();
        t_zero_page();
        t_store80();
        t_lang_card();
        t_io_page();
        t_video_status();
        t_midrun_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule